// File: doc/BRIEF.md
# Converter Start-Up Sequencer

This block decides when a converter datapath may leave reset, when its offset calibration runs, and when its output words can be trusted. An active-low reset input asserts asynchronously and forces everything quiet. Release passes through a clock-domain synchroniser. The sequencer then qualifies the frame clock according to the selected interface mode, holds calibration for a fixed number of frame periods, and finally raises a permanent output enable.

There are three start-up modes. In internal-clock mode, calibration starts as soon as reset has been released. In follower mode, the frame clock is externally driven, and start-up waits for a falling edge followed by a rising edge. In word-gated mode, the word clock must be seen high across a frame-high, frame-low, frame-high sequence. Calibration length is counted only in frame-clock rising edges that arrive after qualification. The block carries no data stream, so all of its pins are plain control and status levels.

Top module: `startup_sequencer`

## Requirements
- R1: While `rst_n` is low, `path_rst_n`, `cal_busy` and `out_enable` are all 0. Assertion of `rst_n` takes effect without waiting for a clock edge.
- R2: Release of `rst_n` is synchronised through two clock stages. One clock edge after release, `path_rst_n` is still 0.
- R3: With `slave_sel`=0 and `wclk_sel`=0, `path_rst_n` and `cal_busy` go to 1 within a few clocks of release. No `lrck` activity is needed for this.
- R4: With `slave_sel`=1 and `wclk_sel`=0, `path_rst_n` stays 0 until the first `lrck` rising edge that follows an `lrck` falling edge seen after release. A rising edge that comes before any falling edge does not qualify.
- R5: With `wclk_sel`=1, `path_rst_n` stays 0 until three conditions have been sampled in order: `wclk`=1 with `lrck`=1, then `wclk`=1 with `lrck`=0, then `wclk`=1 with `lrck`=1. While `wclk`=0 the sequence never advances.
- R6: `wclk_sel`=1 takes precedence over `slave_sel`.
- R7: Calibration lasts exactly `CAL_PERIODS` `lrck` rising edges, counted from entry into calibration. The edge that qualified follower mode is not counted. After the last counted edge, `cal_busy` falls and `out_enable` rises in the same cycle.
- R8: Once `out_enable` is 1, it stays 1 and `cal_busy` stays 0 whatever `lrck` and `wclk` do, until `rst_n` goes low.
- R9: A reset during calibration restarts the whole sequence, and the full `CAL_PERIODS` count is required again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset; assertion asynchronous, also the power-down request |
| slave_sel | input | 1 | 1: frame clock is externally driven (follower mode) |
| wclk_sel | input | 1 | 1: word-gated start-up mode |
| lrck | input | 1 | Frame (left/right) clock, asynchronous to `clk` |
| wclk | input | 1 | Word clock, asynchronous to `clk` |
| path_rst_n | output | 1 | Active-low reset to the datapath |
| cal_busy | output | 1 | Offset calibration in progress |
| out_enable | output | 1 | Output words valid |

## Verification
The assertions take for granted that `slave_sel` and `wclk_sel` are steady from reset release onwards. They also assume that each `lrck` and `wclk` level is held for several `clk` cycles, so that every level survives the two-stage sampler and each edge shows up as exactly one pulse. The stimulus changes mode pins only while reset is held. It changes `lrck` and `wclk` on falling clock edges and keeps each `lrck` half-period at eight clocks. Outputs are sampled at the end of each half-period, well after the sampler latency has elapsed.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_WAIT_FALL,
    ST_WAIT_RISE,
    ST_WC_A,
    ST_WC_B,
    ST_WC_C,
    ST_CAL,
    ST_RUN
  } sseq_state_e;

endpackage

// File: rtl/sseq_rst_sync.sv
module sseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain[STAGES-1];

  // R2: synchronous release only ever follows a high reset input
  assert_release_sync_R2: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(srst_n) |-> $past(arst_n));

endmodule

// File: rtl/sseq_pin_sampler.sv
module sseq_pin_sampler #(
  parameter int WIDTH = 2,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);

  logic [SYNC-1:0][WIDTH-1:0] pipe;
  logic [WIDTH-1:0]           prev;

  always_ff @(posedge clk) begin
    pipe <= {pipe[SYNC-2:0], pin_i};
    prev <= pipe[SYNC-1];
  end

  assign level_o = pipe[SYNC-1];
  assign rise_o  = level_o & ~prev;
  assign fall_o  = ~level_o & prev;

endmodule

// File: rtl/sseq_cal_timer.sv
module sseq_cal_timer #(
  parameter int PERIODS = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);

  localparam int CW = $clog2(PERIODS + 1);

  logic [CW-1:0] cnt;

  assign done_o = (cnt == CW'(PERIODS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run_i)           cnt <= '0;
    else if (tick_i && !done_o) cnt <= cnt + CW'(1);
  end

  // R7: count never passes the terminal value
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(PERIODS));

  // R7: count moves only on a frame-clock tick while running
  assert_cnt_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_i) |=> $stable(cnt) || !$past(run_i) || cnt == '0);

endmodule

// File: rtl/startup_sequencer.sv
module startup_sequencer
  import sseq_pkg::*;
#(
  parameter int CAL_PERIODS = 8192,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slave_sel,
  input  logic wclk_sel,
  input  logic lrck,
  input  logic wclk,
  output logic path_rst_n,
  output logic cal_busy,
  output logic out_enable
);

  localparam int PINS  = 2;
  localparam int P_LR  = 0;
  localparam int P_WC  = 1;

  logic            srst_n;
  logic [PINS-1:0] lvl, rise, fall;
  logic            lrck_lvl, wclk_lvl, lrck_rise, lrck_fall;
  logic            cal_done;
  sseq_state_e     state;

  sseq_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sseq_pin_sampler #(.WIDTH(PINS), .SYNC(SYNC_STAGES)) i_sampler (
    .clk     (clk),
    .pin_i   ({wclk, lrck}),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  assign lrck_lvl  = lvl[P_LR];
  assign wclk_lvl  = lvl[P_WC];
  assign lrck_rise = rise[P_LR];
  assign lrck_fall = fall[P_LR];

  sseq_cal_timer #(.PERIODS(CAL_PERIODS)) i_cal_timer (
    .clk    (clk),
    .rst_n  (srst_n),
    .run_i  (state == ST_CAL),
    .tick_i (lrck_rise),
    .done_o (cal_done)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state <= ST_HOLD;
    end else begin
      unique case (state)
        ST_HOLD: begin
          if (wclk_sel)       state <= ST_WC_A;
          else if (slave_sel) state <= ST_WAIT_FALL;
          else                state <= ST_CAL;
        end
        ST_WAIT_FALL: if (lrck_fall) state <= ST_WAIT_RISE;
        ST_WAIT_RISE: if (lrck_rise) state <= ST_CAL;
        ST_WC_A:      if (wclk_lvl && lrck_lvl)  state <= ST_WC_B;
        ST_WC_B:      if (wclk_lvl && !lrck_lvl) state <= ST_WC_C;
        ST_WC_C:      if (wclk_lvl && lrck_lvl)  state <= ST_CAL;
        ST_CAL:       if (cal_done) state <= ST_RUN;
        ST_RUN:       state <= ST_RUN;
        default:      state <= ST_HOLD;
      endcase
    end
  end

  assign path_rst_n = (state == ST_CAL) || (state == ST_RUN);
  assign cal_busy   = (state == ST_CAL);
  assign out_enable = (state == ST_RUN);

  // R1: everything quiet while the reset input is low
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!path_rst_n && !cal_busy && !out_enable));

  // R4: follower mode leaves reset only on a sampled frame-clock rise
  assert_slave_gate_R4: assert property (@(posedge clk) disable iff (!srst_n)
    ($rose(path_rst_n) && slave_sel && !wclk_sel) |-> $past(lrck_rise));

  // R5 and R6: word-gated mode leaves reset only with both clocks high
  assert_wc_gate_R6: assert property (@(posedge clk) disable iff (!srst_n)
    ($rose(path_rst_n) && wclk_sel) |-> $past(wclk_lvl && lrck_lvl));

  // R7: calibration ends only into the enabled state, after the timer finishes
  assert_cal_exit_R7: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(cal_busy) |-> (out_enable && $past(cal_done)));

  // R8: enable is permanent until reset
  assert_run_holds_R8: assert property (@(posedge clk) disable iff (!srst_n)
    out_enable |=> (out_enable && !cal_busy));

endmodule

// File: tb/test_startup_sequencer.sv
module test_startup_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int CAL        = 4;
  localparam int HALF       = 8;

  typedef struct packed {
    logic        slave;
    logic        wc;
    logic        wclk_lvl;
    logic        lrck0;
    logic [3:0]  qual;
  } row_t;

  localparam int NROWS = 7;
  localparam row_t ROWS [NROWS] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'd0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 4'd0},
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'd2},
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'd1},
    '{1'b0, 1'b1, 1'b1, 1'b0, 4'd2},
    '{1'b0, 1'b1, 1'b1, 1'b1, 4'd1},
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd1}
  };

  logic clk = 1'b0;
  logic rst_n, slave_sel, wclk_sel, lrck, wclk;
  logic path_rst_n, cal_busy, out_enable;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  startup_sequencer #(.CAL_PERIODS(CAL)) i_startup_sequencer (
    .clk        (clk),
    .rst_n      (rst_n),
    .slave_sel  (slave_sel),
    .wclk_sel   (wclk_sel),
    .lrck       (lrck),
    .wclk       (wclk),
    .path_rst_n (path_rst_n),
    .cal_busy   (cal_busy),
    .out_enable (out_enable)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk3(input string req, input logic p, input logic c, input logic o);
    chk(req, "path_rst_n", path_rst_n, p);
    chk(req, "cal_busy",   cal_busy,   c);
    chk(req, "out_enable", out_enable, o);
  endtask

  task automatic lrck_period();
    lrck = 1'b0;
    repeat (HALF) @(negedge clk);
    lrck = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic hold_reset(input logic s, input logic w, input logic wl, input logic l0);
    @(negedge clk);
    rst_n = 1'b0; slave_sel = s; wclk_sel = w; wclk = wl; lrck = l0;
    repeat (4) @(negedge clk);
    chk3("R1", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "path_rst_n one edge after release", path_rst_n, 1'b0);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; slave_sel = 1'b0; wclk_sel = 1'b0; lrck = 1'b0; wclk = 1'b0;
    repeat (3) @(negedge clk);
    chk3("R1", 1'b0, 1'b0, 1'b0);

    for (int r = 0; r < NROWS; r++) begin
      string tag;
      int    q;
      q = int'(ROWS[r].qual);
      tag = ROWS[r].wc ? (ROWS[r].slave ? "R6" : "R5") : (ROWS[r].slave ? "R4" : "R3");
      hold_reset(ROWS[r].slave, ROWS[r].wc, ROWS[r].wclk_lvl, ROWS[r].lrck0);
      chk(tag, "path_rst_n before frame activity", path_rst_n, q == 0);
      for (int p = 1; p <= q + CAL; p++) begin
        lrck_period();
        chk(tag, "path_rst_n per period", path_rst_n, p >= q);
        chk("R7", "cal_busy per period", cal_busy, (p >= q) && (p < q + CAL));
        chk("R7", "out_enable per period", out_enable, p >= q + CAL);
      end
    end

    // R8: enable persists with frame clock stopped and word clock moving
    repeat (20) @(negedge clk);
    wclk = 1'b0;
    repeat (5) @(negedge clk);
    chk3("R8", 1'b1, 1'b0, 1'b1);
    lrck_period();
    lrck_period();
    chk3("R8", 1'b1, 1'b0, 1'b1);

    // R1: asynchronous assertion, no clock edge in between
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk3("R1", 1'b0, 1'b0, 1'b0);

    // R9: reset in the middle of calibration restarts the count
    hold_reset(1'b0, 1'b0, 1'b0, 1'b0);
    lrck_period();
    lrck_period();
    chk("R9", "cal_busy mid calibration", cal_busy, 1'b1);
    hold_reset(1'b0, 1'b0, 1'b0, 1'b0);
    for (int p = 1; p < CAL; p++) lrck_period();
    chk("R9", "out_enable one period short", out_enable, 1'b0);
    lrck_period();
    chk("R9", "out_enable after full count", out_enable, 1'b1);

    // R5 and R6: word clock low blocks word-gated start, even with follower mode set
    hold_reset(1'b1, 1'b1, 1'b0, 1'b1);
    for (int p = 0; p < 3; p++) lrck_period();
    chk("R5", "path_rst_n with wclk low", path_rst_n, 1'b0);
    chk("R6", "follower edges ignored in word-gated mode", cal_busy, 1'b0);
    wclk = 1'b1;
    repeat (6) @(negedge clk);
    lrck_period();
    chk("R5", "path_rst_n after wclk sequence", path_rst_n, 1'b1);
    chk("R5", "cal_busy after wclk sequence", cal_busy, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule